// File: doc/BRIEF.md
# Fast Fault Shutdown Latch

This block supervises a set of inverter half-bridges. It accepts the digitized result of an overcurrent comparator, the sensed logic level of a shared, bidirectional, active-low shutdown pin, an undervoltage flag for the low-voltage supply and one undervoltage flag per leg for the bootstrap supply. It drives a common fault turn-off signal, per-leg high-side and low-side gate-off signals, and the enable of an open-drain transistor that pulls the shared pin low.

A comparator trip turns every gate off at once. The trip is captured in a flop that is set asynchronously, so the turn-off does not wait for any synchronizer. The same trip enables the pull-down on the shared pin. The pull-down is held until the synchronized pin level reads low. It is then released, and the gates stay off until the pin has recharged through its external RC network and reads high again. The total disable time is therefore set by the external RC, not by the comparator pulse width. A comparator pulse shorter than a clock period is still caught by the asynchronous flop and runs the whole sequence. The shared pin can also be pulled low by outside logic, which turns the gates off without engaging the pull-down.

Top module: `fault_shutdown_latch`

## Requirements
- R1: While oc_trip_i is high, gate_off_o and every bit of hs_off_o and ls_off_o are high. No clock edge is needed.
- R2: While oc_trip_i is high, od_pull_o is high. No clock edge is needed.
- R3: After a trip, od_pull_o stays high while the synchronized shutdown pin reads high. It falls once the pin has read low (after SYNC_STAGES clock edges) and the captured trip has cleared through its synchronizer.
- R4: After the pull-down is released, gate_off_o stays high while the pin reads low. It falls only after the pin has read high for SYNC_STAGES clock edges with the comparator inactive.
- R5: With no fault, a low level on sd_pin_i raises gate_off_o within SYNC_STAGES clock edges and leaves od_pull_o low.
- R6: vcc_uv_i high forces every bit of hs_off_o and ls_off_o high without clocking, and has no effect on gate_off_o or od_pull_o.
- R7: boot_uv_i[i] high forces hs_off_o[i] (bit i is leg i) high and leaves ls_off_o[i] and the other legs unchanged.
- R8: A comparator trip while the pull-down is released and the pin is still low raises od_pull_o again and re-enters the pulling phase.
- R9: A comparator pulse that starts and ends between two clock edges still raises od_pull_o and keeps it high until the pin reads low.
- R10: During reset gate_off_o is high and od_pull_o is low, because the sensed pin is taken as low until it has been synchronized.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip_i | input | 1 | Overcurrent comparator result, asynchronous, high on trip |
| sd_pin_i | input | 1 | Sensed level of the shared shutdown pin, asynchronous, low means shutdown |
| vcc_uv_i | input | 1 | Low-voltage supply undervoltage flag |
| boot_uv_i | input | NUM_LEGS | Bootstrap supply undervoltage flag, bit i for leg i |
| gate_off_o | output | 1 | Common fault turn-off for all legs |
| od_pull_o | output | 1 | Enable of the open-drain pull-down on the shared pin |
| hs_off_o | output | NUM_LEGS | High-side gate off, bit i for leg i |
| ls_off_o | output | NUM_LEGS | Low-side gate off, bit i for leg i |

## Verification
The assertions assume that oc_trip_i is low during reset and that the undervoltage flags are already synchronous to clk. The turn-off properties are sampled only at clock edges, so a comparator pulse that falls before the next edge is checked by the reference model and not by them. The stimulus changes every input on the falling clock edge, keeps the comparator low while reset is applied, and emulates the external RC by letting the pin fall a few cycles after the pull-down turns on and recover a few cycles after it turns off. Sub-cycle comparator pulses are applied only in a directed case.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   typedef enum logic [1:0] {
      FSL_IDLE = 2'd0,
      FSL_PULL = 2'd1,
      FSL_HOLD = 2'd2
   } fsl_state_e;
endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fsl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsl_trip_latch.sv
module fsl_trip_latch #(
   parameter bit FAST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_i,
   input  logic clr_i,
   output logic q_o
);
   logic latch_q;

   generate
      if (FAST) begin : g_async_set
         // the trip sets the flop without a clock; clearing is clocked
         always_ff @(posedge clk or negedge rst_n or posedge trip_i) begin
            if (trip_i)      latch_q <= 1'b1;
            else if (!rst_n) latch_q <= 1'b0;
            else if (clr_i)  latch_q <= 1'b0;
         end
      end else begin : g_sync_set
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      latch_q <= 1'b0;
            else if (trip_i) latch_q <= 1'b1;
            else if (clr_i)  latch_q <= 1'b0;
         end
      end
   endgenerate

   assign q_o = latch_q;
endmodule

// File: rtl/fsl_seq.sv
module fsl_seq
   import fsl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fault_req_i,
   input  logic       pin_high_i,
   output fsl_state_e state_o
);
   fsl_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FSL_IDLE: if (fault_req_i) state_d = FSL_PULL;
         FSL_PULL: if (!pin_high_i && !fault_req_i) state_d = FSL_HOLD;
         FSL_HOLD: begin
            if (fault_req_i)     state_d = FSL_PULL;
            else if (pin_high_i) state_d = FSL_IDLE;
         end
         default: state_d = FSL_PULL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FSL_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/fsl_leg_gate.sv
module fsl_leg_gate (
   input  logic fault_off_i,
   input  logic vcc_uv_i,
   input  logic boot_uv_i,
   output logic hs_off_o,
   output logic ls_off_o
);
   logic common_off;

   assign common_off = fault_off_i | vcc_uv_i;
   assign ls_off_o   = common_off;
   assign hs_off_o   = common_off | boot_uv_i;
endmodule

// File: rtl/fault_shutdown_latch.sv
module fault_shutdown_latch
   import fsl_pkg::*;
#(
   parameter int NUM_LEGS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit FAST_TRIP   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                oc_trip_i,
   input  logic                sd_pin_i,
   input  logic                vcc_uv_i,
   input  logic [NUM_LEGS-1:0] boot_uv_i,
   output logic                gate_off_o,
   output logic                od_pull_o,
   output logic [NUM_LEGS-1:0] hs_off_o,
   output logic [NUM_LEGS-1:0] ls_off_o
);
   generate
      if (NUM_LEGS < 1) begin : g_bad_legs
         $error("fault_shutdown_latch: NUM_LEGS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fault_shutdown_latch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       pin_s;
   logic       trip_q;
   logic       trip_seen;
   logic       in_pull;
   logic       fault_off;
   fsl_state_e seq_state;

   // pin reads as shutdown until it has been synchronized
   fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sd_pin_i),
      .q_o   (pin_s)
   );

   fsl_trip_latch #(.FAST(FAST_TRIP)) u_trip (
      .clk    (clk),
      .rst_n  (rst_n),
      .trip_i (oc_trip_i),
      .clr_i  (in_pull),
      .q_o    (trip_q)
   );

   // the sequencer only sees the captured trip after synchronization
   fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_trip_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (trip_q),
      .q_o   (trip_seen)
   );

   fsl_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_req_i (trip_seen),
      .pin_high_i  (pin_s),
      .state_o     (seq_state)
   );

   assign in_pull    = (seq_state == FSL_PULL);
   assign fault_off  = trip_q | (seq_state != FSL_IDLE) | ~pin_s;
   assign gate_off_o = fault_off;
   assign od_pull_o  = trip_q | in_pull;

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         fsl_leg_gate u_leg (
            .fault_off_i (fault_off),
            .vcc_uv_i    (vcc_uv_i),
            .boot_uv_i   (boot_uv_i[g]),
            .hs_off_o    (hs_off_o[g]),
            .ls_off_o    (ls_off_o[g])
         );
      end
   endgenerate
endmodule

// File: rtl/fault_shutdown_latch_chk.sv
module fault_shutdown_latch_chk #(
   parameter int NUM_LEGS  = 3,
   parameter bit FAST_TRIP = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                oc_trip_i,
   input logic                vcc_uv_i,
   input logic                gate_off_o,
   input logic                od_pull_o,
   input logic [NUM_LEGS-1:0] hs_off_o,
   input logic [NUM_LEGS-1:0] ls_off_o
);
   generate
      if (FAST_TRIP) begin : g_fast
         a_r1_trip_kills_gates: assert property (@(posedge clk) disable iff (!rst_n)
            oc_trip_i |-> (gate_off_o && (&hs_off_o) && (&ls_off_o)));
         a_r2_trip_pulls_pin: assert property (@(posedge clk) disable iff (!rst_n)
            oc_trip_i |-> od_pull_o);
      end
   endgenerate

   a_r3_pull_only_with_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
      od_pull_o |-> gate_off_o);

   a_r4_release_keeps_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(od_pull_o) |-> gate_off_o);

   a_r6_supply_uv_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_uv_i |-> ((&hs_off_o) && (&ls_off_o)));

   a_r7_high_side_covers_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_off_o & ~hs_off_o) == '0);
endmodule

bind fault_shutdown_latch fault_shutdown_latch_chk #(
   .NUM_LEGS  (NUM_LEGS),
   .FAST_TRIP (FAST_TRIP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .oc_trip_i  (oc_trip_i),
   .vcc_uv_i   (vcc_uv_i),
   .gate_off_o (gate_off_o),
   .od_pull_o  (od_pull_o),
   .hs_off_o   (hs_off_o),
   .ls_off_o   (ls_off_o)
);

// File: tb/fault_shutdown_latch_test.sv
`timescale 1ns/1ps
module fault_shutdown_latch_test;
   localparam int N    = 3;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         oc = 1'b0;
   logic         pin = 1'b1;
   logic         vuv = 1'b0;
   logic [N-1:0] buv = '0;
   logic         gate_off, od_pull;
   logic [N-1:0] hs_off, ls_off;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   bit rc_on = 0;
   int dis_cnt = 0;
   int chg_cnt = 0;

   always #4 clk = ~clk;

   fault_shutdown_latch #(.NUM_LEGS(N), .SYNC_STAGES(SYNC), .FAST_TRIP(1'b1)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .oc_trip_i  (oc),
      .sd_pin_i   (pin),
      .vcc_uv_i   (vuv),
      .boot_uv_i  (buv),
      .gate_off_o (gate_off),
      .od_pull_o  (od_pull),
      .hs_off_o   (hs_off),
      .ls_off_o   (ls_off)
   );

   // behavioural reference: 0 idle, 1 pulling, 2 released and waiting
   bit m_pin_q[$];
   bit m_ts_q[$];
   bit m_trip;
   int m_state;

   task automatic model_init();
      m_pin_q.delete();
      m_ts_q.delete();
      for (int i = 0; i < SYNC; i++) begin
         m_pin_q.push_back(1'b0);
         m_ts_q.push_back(1'b0);
      end
      m_trip  = 1'b0;
      m_state = 0;
   endtask

   initial model_init();

   always @(posedge oc) m_trip = 1'b1;

   always @(posedge clk) begin
      bit req, pins, tq;
      int ns;
      if (!rst_n) model_init();
      else begin
         req  = m_ts_q[0];
         pins = m_pin_q[0];
         tq   = m_trip | oc;
         ns   = m_state;
         case (m_state)
            0: if (req) ns = 1;
            1: if (!pins && !req) ns = 2;
            default: if (req) ns = 1; else if (pins) ns = 0;
         endcase
         if (oc) m_trip = 1'b1;
         else if (m_state == 1) m_trip = 1'b0;
         else m_trip = tq;
         void'(m_pin_q.pop_front());
         m_pin_q.push_back(pin);
         void'(m_ts_q.pop_front());
         m_ts_q.push_back(tq);
         m_state = ns;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic e_trip, e_gate, e_pull;
      logic [N-1:0] e_hs, e_ls;
      if (!rst_n) return;
      e_trip = m_trip | oc;
      e_gate = e_trip | (m_state != 0) | !m_pin_q[0];
      e_pull = e_trip | (m_state == 1);
      e_ls   = {N{e_gate | vuv}};
      e_hs   = e_ls | buv;
      chk("R4 model gate_off", gate_off, e_gate);
      chk("R3 model od_pull", od_pull, e_pull);
      chk("R7 model hs_off", hs_off, e_hs);
      chk("R6 model ls_off", ls_off, e_ls);
   endtask

   task automatic rc_update();
      if (od_pull) begin
         chg_cnt = 0;
         if (dis_cnt < 3) dis_cnt++; else pin = 1'b0;
      end else begin
         dis_cnt = 0;
         if (chg_cnt < 6) chg_cnt++; else pin = 1'b1;
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(negedge clk);
         compare();
         if (rc_on) rc_update();
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      step(3);
      chk("R10 gate_off in reset", gate_off, 1'b1);
      chk("R10 od_pull in reset", od_pull, 1'b0);
      rst_n = 1'b1;
      step(4);
      chk("R10 gates enabled after pin sync", gate_off, 1'b0);

      // R1 R2 immediate trip path
      oc = 1'b1;
      #1;
      chk("R1 gate_off without clock", gate_off, 1'b1);
      chk("R1 all high sides off", hs_off, {N{1'b1}});
      chk("R1 all low sides off", ls_off, {N{1'b1}});
      chk("R2 pull-down without clock", od_pull, 1'b1);
      step(3);
      oc = 1'b0;
      step(6);
      chk("R3 pull held while pin high", od_pull, 1'b1);
      pin = 1'b0;
      step(SYNC + 2);
      chk("R3 pull released after pin low", od_pull, 1'b0);
      chk("R4 gates off while pin low", gate_off, 1'b1);
      step(5);
      chk("R4 still off during recharge", gate_off, 1'b1);

      // R8 trip while released
      oc = 1'b1;
      #1;
      chk("R8 pull re-asserted in hold", od_pull, 1'b1);
      step(4);
      chk("R8 pulling phase re-entered", od_pull, 1'b1);
      oc = 1'b0;
      step(8);
      chk("R8 released again once trip clears", od_pull, 1'b0);
      pin = 1'b1;
      step(1);
      chk("R4 off until pin synchronized", gate_off, 1'b1);
      step(SYNC + 1);
      chk("R4 gates back on after recharge", gate_off, 1'b0);

      // R9 short pulse between edges
      oc = 1'b1;
      #1;
      oc = 1'b0;
      step(4);
      chk("R9 short pulse captured", od_pull, 1'b1);
      chk("R9 short pulse gates off", gate_off, 1'b1);
      pin = 1'b0;
      step(SYNC + 4);
      chk("R9 pull released", od_pull, 1'b0);
      pin = 1'b1;
      step(SYNC + 2);
      chk("R9 sequence complete", gate_off, 1'b0);

      // R5 external shutdown
      pin = 1'b0;
      step(SYNC);
      chk("R5 external shutdown gates off", gate_off, 1'b1);
      chk("R5 no pull on external shutdown", od_pull, 1'b0);
      pin = 1'b1;
      step(SYNC + 1);
      chk("R5 external shutdown ends", gate_off, 1'b0);

      // R6 supply undervoltage
      vuv = 1'b1;
      #1;
      chk("R6 all high sides off", hs_off, {N{1'b1}});
      chk("R6 all low sides off", ls_off, {N{1'b1}});
      chk("R6 gate_off untouched", gate_off, 1'b0);
      chk("R6 od_pull untouched", od_pull, 1'b0);
      step(2);
      vuv = 1'b0;

      // R7 bootstrap undervoltage on leg 1
      buv = 3'b010;
      #1;
      chk("R7 only leg1 high side off", hs_off, 3'b010);
      chk("R7 low sides on", ls_off, 3'b000);
      step(2);
      buv = '0;
      step(2);

      // RC-emulated and randomized run
      rc_on = 1;
      for (int c = 0; c < 3000; c++) begin
         oc  = (($urandom % 50) == 0) ? 1'b1 : (oc && (($urandom % 3) != 0));
         vuv = (($urandom % 80) == 0);
         buv = (($urandom % 20) == 0) ? N'($urandom) : '0;
         step(1);
      end
      oc = 1'b0; vuv = 1'b0; buv = '0;
      step(60);
      chk("R4 idle after RC run", gate_off, 1'b0);
      chk("R3 pull off after RC run", od_pull, 1'b0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule